// File: doc/BRIEF.md
# Real and Complex Fixed-Point ALU

This block is a two-stage fixed-point arithmetic and logic unit. It works either on plain signed words or on packed complex words, and a data-type select chooses which. In real mode it adds, subtracts, increments, decrements, multiplies to a double-width product, and applies eight bitwise functions. In complex mode each operand word carries two signed lanes. The upper half is the real part and the lower half is the imaginary part. The unit adds or subtracts the lanes independently, or forms the conjugate of operand A.

A single segmented adder serves every add-type operation. Its lower half is a parallel-prefix adder. Its upper half is a carry-select pair of prefix adders. In real mode the select is driven by the lower half's carry. In complex mode it is driven by a separate lane carry-in, which keeps the two lanes apart. The inputs are captured on a cycle where `in_valid` is high. The result, flags and `out_valid` appear one cycle later, and a new operation can be issued on every cycle.

Top module: `fx_alu_rc`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge produces its result, flags and a one-cycle `out_valid` pulse after the next rising edge (two edges from input to output). Back-to-back inputs give back-to-back results in issue order.
- R2: Real add (`op`=0) and subtract (`op`=1) return A+B or A-B modulo 2^DW in `res_lo`. `carry_out[0]` is the adder carry, which for subtract means no borrow (A >= B unsigned). `ovf[0]` flags signed overflow. `carry_out[1]`, `ovf[1]` and `res_hi` are 0.
- R3: Real increment (`op`=2) returns A+1 and real decrement (`op`=3) returns A-1, using the same adder with B forced to +1 or all ones. Carry and overflow are reported as in R2.
- R4: Real multiply (`op`=4) returns the signed 2*DW-bit product of A and B, with the upper word in `res_hi` and the lower word in `res_lo`. Both flag vectors are 0.
- R5: The real logic operations are AND=5, OR=6, NAND=7, NOR=8, XOR=9, XNOR=10, NOT A=11 and pass A=12. They return the bitwise result in `res_lo`, with `res_hi` and all flags 0.
- R6: With `cplx`=1, add (`op`=0) and subtract (`op`=1) work separately on the upper (real) and lower (imaginary) halves. No carry crosses from one lane to the other. `carry_out[1]`/`ovf[1]` belong to the upper lane and `carry_out[0]`/`ovf[0]` to the lower lane.
- R7: With `cplx`=1, conjugate (`op`=13) keeps A's upper half and replaces its lower half with the two's-complement negation. The lower-lane carry is set when the imaginary part is 0, and the lower-lane overflow is set when it is the most negative value. The upper-lane flags are 0.
- R8: Any other combination gives all-zero result and flags: opcode 13 in real mode, opcodes 2 to 12 in complex mode, and opcodes 14 and 15 in either mode.
- R9: While `rst` is high, `out_valid`, `res_lo`, `res_hi`, `carry_out` and `ovf` are 0, whatever the other inputs are.
- R10: Cycles with `in_valid` low produce no `out_valid` pulse and leave all result and flag outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Operation code (see R2 to R8) |
| cplx | input | 1 | 1 selects packed complex operands, 0 selects real |
| a | input | DW | Operand A |
| b | input | DW | Operand B |
| out_valid | output | 1 | Result strobe |
| res_lo | output | DW | Result, or lower product word |
| res_hi | output | DW | Upper product word, otherwise 0 |
| carry_out | output | 2 | Carry flags: [1] upper lane, [0] lower lane or full word |
| ovf | output | 2 | Signed overflow flags, same lane layout as carry_out |

## Verification
A fault in the operand steering or in the lane split does not stay hidden inside the unit. It shows on `res_lo` and the flag pins at the second edge after the faulty operation is issued. A lane-isolation fault shows as an upper half that is off by one after a lower-lane wrap. A carry-select fault shows as a wrong high byte on any real add that carries out of the low half. A stage-valid fault shows as a missing or extra `out_valid` pulse in the same cycle, and it also leaves the scoreboard with a leftover or missing entry. The corner operands are chosen so that each flag is driven to both values in both modes: the signed limits, all ones, zero, and the most negative lane value.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_MUL  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_NAND = 4'd7,
        OP_NOR  = 4'd8,
        OP_XOR  = 4'd9,
        OP_XNOR = 4'd10,
        OP_NOT  = 4'd11,
        OP_BUF  = 4'd12,
        OP_CONJ = 4'd13
    } op_e;

    // lane flags: index 1 = upper lane, index 0 = lower lane / full word
    typedef struct packed {
        logic [1:0] cy;
        logic [1:0] ov;
    } flag_t;

    function automatic logic is_logic_op(logic [3:0] o);
        return (o >= OP_AND) && (o <= OP_BUF);
    endfunction

endpackage

// File: rtl/prefix_add.sv
// Parallel-prefix (log-depth) adder with carry-in.
module prefix_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] gl [0:LV];
    logic [W-1:0] pl [0:LV];
    logic [W-1:0] cv;

    assign gl[0] = x & y;
    assign pl[0] = x ^ y;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int D = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_merge
                assign gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][i-D]);
                assign pl[l+1][i] = pl[l][i] & pl[l][i-D];
            end else begin : g_pass
                assign gl[l+1][i] = gl[l][i];
                assign pl[l+1][i] = pl[l][i];
            end
        end
    end

    assign cv[0] = cin;
    for (genvar i = 1; i < W; i++) begin : g_carry
        assign cv[i] = gl[LV][i-1] | (pl[LV][i-1] & cin);
    end

    assign sum  = pl[0] ^ cv;
    assign cout = gl[LV][W-1] | (pl[LV][W-1] & cin);

endmodule

// File: rtl/seg_adder.sv
// Segmented adder: prefix lower half, carry-select upper half.
// split=1 cuts the carry between halves (two independent lanes).
module seg_adder #(
    parameter int DW = 16
) (
    input  logic          split,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin_lo,
    input  logic          cin_hi,
    output logic [DW-1:0] sum,
    output logic [1:0]    cy,
    output logic [1:0]    ov
);
    localparam int HW = DW / 2;

    logic [HW-1:0] s_lo, s_up0, s_up1, s_up;
    logic          c_lo, c_up0, c_up1, c_up, sel;
    logic          ov_lo, ov_up;

    prefix_add #(.W(HW)) u_lo (
        .x(x[HW-1:0]), .y(y[HW-1:0]), .cin(cin_lo), .sum(s_lo), .cout(c_lo)
    );
    prefix_add #(.W(HW)) u_up0 (
        .x(x[DW-1:HW]), .y(y[DW-1:HW]), .cin(1'b0), .sum(s_up0), .cout(c_up0)
    );
    prefix_add #(.W(HW)) u_up1 (
        .x(x[DW-1:HW]), .y(y[DW-1:HW]), .cin(1'b1), .sum(s_up1), .cout(c_up1)
    );

    assign sel  = split ? cin_hi : c_lo;
    assign s_up = sel ? s_up1 : s_up0;
    assign c_up = sel ? c_up1 : c_up0;
    assign sum  = {s_up, s_lo};

    assign ov_up = (x[DW-1] == y[DW-1]) && (s_up[HW-1] != x[DW-1]);
    assign ov_lo = (x[HW-1] == y[HW-1]) && (s_lo[HW-1] != x[HW-1]);

    assign cy = split ? {c_up, c_lo}   : {1'b0, c_up};
    assign ov = split ? {ov_up, ov_lo} : {1'b0, ov_up};

endmodule

// File: rtl/logic_unit.sv
module logic_unit #(
    parameter int DW = 16
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] z
);
    import fxalu_pkg::*;

    always_comb begin
        case (op)
            OP_AND:  z = x & y;
            OP_OR:   z = x | y;
            OP_NAND: z = ~(x & y);
            OP_NOR:  z = ~(x | y);
            OP_XOR:  z = x ^ y;
            OP_XNOR: z = ~(x ^ y);
            OP_NOT:  z = ~x;
            OP_BUF:  z = x;
            default: z = '0;
        endcase
    end

endmodule

// File: rtl/mult_unit.sv
module mult_unit #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    output logic [2*DW-1:0] p
);
    logic signed [2*DW-1:0] xs, ys;

    assign xs = {{DW{x[DW-1]}}, x};
    assign ys = {{DW{y[DW-1]}}, y};
    assign p  = xs * ys;

endmodule

// File: rtl/fx_alu_rc.sv
module fx_alu_rc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic          cplx,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          out_valid,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic [1:0]    carry_out,
    output logic [1:0]    ovf
);
    import fxalu_pkg::*;

    localparam int HW = DW / 2;

    // stage 1: captured operands
    logic          v1;
    logic [3:0]    op_q;
    logic          cplx_q;
    logic [DW-1:0] a_q, b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1     <= 1'b0;
            op_q   <= '0;
            cplx_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                op_q   <= op;
                cplx_q <= cplx;
                a_q    <= a;
                b_q    <= b;
            end
        end
    end

    // operand steering into the shared adder
    logic          use_add, cin_lo, cin_hi;
    logic [DW-1:0] add_a, add_b, add_sum, lu_y;
    logic [1:0]    add_cy, add_ov;
    logic [2*DW-1:0] prod;

    always_comb begin
        use_add = 1'b0;
        add_a   = a_q;
        add_b   = b_q;
        cin_lo  = 1'b0;
        cin_hi  = 1'b0;
        if (!cplx_q) begin
            case (op_q)
                OP_ADD: use_add = 1'b1;
                OP_SUB: begin use_add = 1'b1; add_b = ~b_q; cin_lo = 1'b1; end
                OP_INC: begin use_add = 1'b1; add_b = DW'(1); end
                OP_DEC: begin use_add = 1'b1; add_b = '1; end
                default: ;
            endcase
        end else begin
            case (op_q)
                OP_ADD: use_add = 1'b1;
                OP_SUB: begin
                    use_add = 1'b1; add_b = ~b_q; cin_lo = 1'b1; cin_hi = 1'b1;
                end
                OP_CONJ: begin
                    use_add = 1'b1;
                    add_a   = {a_q[DW-1:HW], {HW{1'b0}}};
                    add_b   = {{HW{1'b0}}, ~a_q[HW-1:0]};
                    cin_lo  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    seg_adder #(.DW(DW)) u_add (
        .split(cplx_q), .x(add_a), .y(add_b), .cin_lo(cin_lo), .cin_hi(cin_hi),
        .sum(add_sum), .cy(add_cy), .ov(add_ov)
    );

    logic_unit #(.DW(DW)) u_log (.op(op_q), .x(a_q), .y(b_q), .z(lu_y));

    mult_unit #(.DW(DW)) u_mul (.x(a_q), .y(b_q), .p(prod));

    // result select
    logic [DW-1:0] nxt_lo, nxt_hi;
    flag_t         nxt_f;

    always_comb begin
        nxt_lo = '0;
        nxt_hi = '0;
        nxt_f  = '0;
        if (use_add) begin
            nxt_lo   = add_sum;
            nxt_f.cy = add_cy;
            nxt_f.ov = add_ov;
        end else if (!cplx_q && op_q == OP_MUL) begin
            {nxt_hi, nxt_lo} = prod;
        end else if (!cplx_q && is_logic_op(op_q)) begin
            nxt_lo = lu_y;
        end
    end

    // stage 2: outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
            carry_out <= '0;
            ovf       <= '0;
        end else begin
            out_valid <= v1;
            if (v1) begin
                res_lo    <= nxt_lo;
                res_hi    <= nxt_hi;
                carry_out <= nxt_f.cy;
                ovf       <= nxt_f.ov;
            end
        end
    end

    // R2 R3
    real_add_chk: assert property (@(posedge clk) disable iff (rst)
        (use_add && !cplx_q) |->
        ({add_cy[0], add_sum} == ({1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, cin_lo})));

    // R6
    lane_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (use_add && cplx_q) |->
        (add_sum[HW-1:0] == HW'(add_a[HW-1:0] + add_b[HW-1:0] + {{(HW-1){1'b0}}, cin_lo})));

    // R6
    lane_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (use_add && cplx_q) |->
        (add_sum[DW-1:HW] == HW'(add_a[DW-1:HW] + add_b[DW-1:HW] + {{(HW-1){1'b0}}, cin_hi})));

    // R5
    logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (v1 && !cplx_q && is_logic_op(op_q)) |=> (carry_out == 2'b00 && ovf == 2'b00 && res_hi == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !v1 |=> ($stable(res_lo) && $stable(res_hi) && $stable(carry_out) && $stable(ovf)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && res_lo == '0 && res_hi == '0 && carry_out == 2'b00 && ovf == 2'b00));

endmodule

// File: tb/sim_fx_alu_rc.sv
module sim_fx_alu_rc;

    localparam int DW = 16;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [3:0]    op = '0;
    logic          cplx = 1'b0;
    logic [DW-1:0] a = '0, b = '0;
    logic          out_valid;
    logic [DW-1:0] res_lo, res_hi;
    logic [1:0]    carry_out, ovf;

    always #5 clk = ~clk;

    fx_alu_rc #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cplx(cplx),
        .a(a), .b(b), .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
        .carry_out(carry_out), .ovf(ovf)
    );

    typedef struct {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [1:0]    cy;
        logic [1:0]    ov;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   mon_on = 1'b0;

    // lane arithmetic from the requirements: w-bit signed add or subtract
    function automatic void lane(input int w, input longint ua, input longint ub,
                                 input bit sub, output longint s,
                                 output bit cy, output bit ov);
        longint m, sa, sb, r;
        m  = longint'(1) << w;
        sa = (ua >= m / 2) ? ua - m : ua;
        sb = (ub >= m / 2) ? ub - m : ub;
        r  = sub ? sa - sb : sa + sb;
        ov = (r > m / 2 - 1) || (r < -(m / 2));
        s  = r & (m - 1);
        cy = sub ? (ua >= ub) : (ua + ub >= m);
    endfunction

    function automatic exp_t model(input logic [3:0] o, input bit c,
                                   input logic [DW-1:0] x, input logic [DW-1:0] y);
        exp_t   e;
        longint s, s2, p;
        bit     c1, o1, c2, o2;
        e.lo = '0; e.hi = '0; e.cy = '0; e.ov = '0; e.tag = "R8";
        if (!c) begin
            case (o)
                4'd0, 4'd1, 4'd2, 4'd3: begin
                    if (o == 4'd0) lane(DW, longint'(x), longint'(y), 1'b0, s, c1, o1);
                    else if (o == 4'd1) lane(DW, longint'(x), longint'(y), 1'b1, s, c1, o1);
                    else if (o == 4'd2) lane(DW, longint'(x), 1, 1'b0, s, c1, o1);
                    else lane(DW, longint'(x), 65535, 1'b0, s, c1, o1);
                    e.lo = s[DW-1:0]; e.cy = {1'b0, c1}; e.ov = {1'b0, o1};
                    e.tag = (o < 4'd2) ? "R2" : "R3";
                end
                4'd4: begin
                    p = longint'($signed(x)) * longint'($signed(y));
                    e.lo = p[DW-1:0]; e.hi = p[2*DW-1:DW]; e.tag = "R4";
                end
                4'd5:  begin e.lo = x & y;    e.tag = "R5"; end
                4'd6:  begin e.lo = x | y;    e.tag = "R5"; end
                4'd7:  begin e.lo = ~(x & y); e.tag = "R5"; end
                4'd8:  begin e.lo = ~(x | y); e.tag = "R5"; end
                4'd9:  begin e.lo = x ^ y;    e.tag = "R5"; end
                4'd10: begin e.lo = ~(x ^ y); e.tag = "R5"; end
                4'd11: begin e.lo = ~x;       e.tag = "R5"; end
                4'd12: begin e.lo = x;        e.tag = "R5"; end
                default: ;
            endcase
        end else begin
            case (o)
                4'd0, 4'd1: begin
                    lane(HW, longint'(x[DW-1:HW]), longint'(y[DW-1:HW]), o[0], s, c1, o1);
                    lane(HW, longint'(x[HW-1:0]), longint'(y[HW-1:0]), o[0], s2, c2, o2);
                    e.lo = {s[HW-1:0], s2[HW-1:0]}; e.cy = {c1, c2}; e.ov = {o1, o2};
                    e.tag = "R6";
                end
                4'd13: begin
                    lane(HW, 0, longint'(x[HW-1:0]), 1'b1, s2, c2, o2);
                    e.lo = {x[DW-1:HW], s2[HW-1:0]}; e.cy = {1'b0, c2}; e.ov = {1'b0, o2};
                    e.tag = "R7";
                end
                default: ;
            endcase
        end
        return e;
    endfunction

    task automatic send(input logic [3:0] o, input bit c,
                        input logic [DW-1:0] x, input logic [DW-1:0] y);
        @(negedge clk);
        in_valid = 1'b1; op = o; cplx = c; a = x; b = y;
        q.push_back(model(o, c, x, y));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (mon_on && !rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({res_hi, res_lo, carry_out, ovf} == {e.hi, e.lo, e.cy, e.ov}, e.tag,
                      "result {hi,lo,cy,ov}",
                      longint'({res_hi, res_lo, carry_out, ovf}),
                      longint'({e.hi, e.lo, e.cy, e.ov}));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [DW-1:0] snap;
        // R9: reset dominates even with in_valid high
        in_valid = 1'b1; op = 4'd4; a = 16'h7FFF; b = 16'h7FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && res_lo == 0 && res_hi == 0 && carry_out == 0 && ovf == 0,
              "R9", "reset outputs", longint'({out_valid, res_hi, res_lo, carry_out, ovf}), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        mon_on = 1'b1;

        // R1: latency of one isolated operation
        send(4'd0, 1'b0, 16'h0003, 16'h0004);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1", "out_valid one cycle after issue", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", "out_valid two edges after issue", out_valid, 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid single pulse", out_valid, 0);

        // R2 real add / subtract, issued back to back
        send(4'd0, 1'b0, 16'h7FFF, 16'h0001);
        send(4'd0, 1'b0, 16'hFFFF, 16'h0001);
        send(4'd0, 1'b0, 16'h8000, 16'h8000);
        send(4'd0, 1'b0, 16'h00FF, 16'h0001);
        send(4'd1, 1'b0, 16'h0005, 16'h0003);
        send(4'd1, 1'b0, 16'h0003, 16'h0005);
        send(4'd1, 1'b0, 16'h8000, 16'h0001);
        // R3 increment / decrement
        send(4'd2, 1'b0, 16'h7FFF, 16'h1234);
        send(4'd2, 1'b0, 16'hFFFF, 16'h0000);
        send(4'd3, 1'b0, 16'h0000, 16'h5555);
        send(4'd3, 1'b0, 16'h8000, 16'h0000);
        // R4 multiply
        send(4'd4, 1'b0, 16'hFFFF, 16'h0002);
        send(4'd4, 1'b0, 16'h8000, 16'h8000);
        send(4'd4, 1'b0, 16'd300, 16'd200);
        // R5 logic set
        for (int k = 5; k <= 12; k++) send(4'(k), 1'b0, 16'hF0A5, 16'h3C3C);
        // R6 complex lanes
        send(4'd0, 1'b1, 16'h7F01, 16'h0101);
        send(4'd0, 1'b1, 16'h00FF, 16'h0001);
        send(4'd1, 1'b1, 16'h1005, 16'h2003);
        send(4'd1, 1'b1, 16'h8000, 16'h0100);
        // R7 conjugate
        send(4'd13, 1'b1, 16'h3480, 16'hFFFF);
        send(4'd13, 1'b1, 16'h1200, 16'h0000);
        send(4'd13, 1'b1, 16'h12FB, 16'h0000);
        // R8 unsupported combinations
        send(4'd13, 1'b0, 16'h1234, 16'h5678);
        send(4'd4, 1'b1, 16'h1234, 16'h5678);
        send(4'd5, 1'b1, 16'hFFFF, 16'hFFFF);
        send(4'd15, 1'b0, 16'hFFFF, 16'h0001);
        send(4'd9, 1'b0, 16'hA5A5, 16'h0F0F);
        idle();
        repeat (4) @(negedge clk);

        // R10: idle cycles with garbage inputs change nothing
        snap = res_lo;
        for (int k = 0; k < 5; k++) begin
            op = 4'(k); cplx = k[0]; a = 16'hDEAD + 16'(k); b = 16'hBEEF;
            @(negedge clk);
            check(!out_valid && res_lo == snap && res_hi == 0 && carry_out == 0 && ovf == 0,
                  "R10", "outputs while idle", longint'({out_valid, res_lo}), longint'({1'b0, snap}));
        end

        // R1: every issued operation produced exactly one result
        check(q.size() == 0, "R1", "pending results", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule